// File: doc/BRIEF.md
# Slice-Hash Congruence Filter

This block picks, out of a stream of physical addresses, those that fall into the same last-level cache set and the same cache slice as a reference address. Software or a test engine uses the resulting group of addresses to build an eviction group. The slice is chosen by XOR parity over fixed upper address bits. Two addresses are congruent when their low 17 bits agree and their slice numbers agree. An optional test bit can be folded into the hash to check whether a guessed hash is correct.

A pulse on `start_i` latches the reference, the target count, the slice mode and the test-bit selector. The reference is emitted as entry 0. After that, candidates are taken one per valid/ready handshake. The candidate's hash is registered one cycle ahead of the compare. Each congruent candidate is emitted with its entry index. The search stops when the found count reaches the target. It also stops, with an error, when a candidate at or beyond the end of the 16 MiB search window reaches the compare stage first.

The controller has five states:
- IDLE: after reset.
- PREP: computes the reference hash and emits entry 0.
- SCAN: takes and compares candidates.
- DONE: target reached.
- FAIL: window overrun.

Transitions:
- start: any state to PREP.
- reference-only: PREP to DONE, when the effective target is 1.
- armed: PREP to SCAN.
- complete: SCAN to DONE, on the match that brings the count to the target.
- overrun: SCAN to FAIL.

Top module: `slice_congr_filter`

## Requirements
- R1: After reset the block is in IDLE: `cand_ready_o`, `match_valid_o`, `done_o` and `err_o` are 0, and `found_o` is 0.
- R2: The cycle after `start_i` is sampled, `found_o` is 0. One cycle later, `match_valid_o` pulses with `match_addr_o` equal to the reference, `match_idx_o` = 0, and `found_o` = 1.
- R3: In 2-slice mode (`mode4_i`=0) the slice number is the XOR of address bits 17,18,20,22,24,25,26,27,28,30. A candidate is congruent only if `addr[16:0]` equals the reference's and the slice numbers are equal.
- R4: In 4-slice mode (`mode4_i`=1) the slice number is {h2,h1}. h1 is the parity of bits 18,19,21,23,25,27,29,30,31. h2 is the parity of bits 17,19,20,21,22,23,24,26,28,29,31.
- R5: With `test_en_i`=1 and `test_sel_i` in 17..31, address bit `test_sel_i` is XORed into slice bit 0 in both modes. A disabled selector, or a selector value below 17, has no effect.
- R6: A non-congruent candidate produces no match pulse and leaves `found_o` unchanged.
- R7: A congruent candidate accepted at clock edge e gives a one-cycle `match_valid_o` pulse after edge e+1. The pulse carries that candidate's address and `match_idx_o` equal to the found count before the match; `found_o` then increments.
- R8: `done_o` rises on the match that makes `found_o` equal to the target. A target of 0 or 1 completes on the reference alone. In DONE, `cand_ready_o` is 0 and candidates are ignored.
- R9: A candidate whose address is ≥ reference + 0x1000000 puts the block in FAIL when it reaches the compare stage in SCAN. `err_o` is then 1, no match is emitted, and `cand_ready_o` drops.
- R10: `start_i` restarts from any state: it clears the count and the error. A candidate sitting at the compare stage in that same cycle emits no match.
- R11: A candidate accepted in the same cycle as the completing match is discarded: no second pulse, and `found_o` stays at the target.
- R12: `cand_ready_o` is 1 exactly while the block is in SCAN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new search, latching the parameters below |
| ref_addr_i | input | 32 | Reference physical address |
| target_i | input | CNT_W | Number of congruent addresses wanted, reference included |
| mode4_i | input | 1 | 0: 2-slice hash, 1: 4-slice hash |
| test_en_i | input | 1 | Enable the test-bit fold |
| test_sel_i | input | 5 | Address bit folded into the hash (17..31) |
| cand_valid_i | input | 1 | Candidate address valid |
| cand_addr_i | input | 32 | Candidate physical address |
| cand_ready_o | output | 1 | Candidate accepted when high with valid |
| match_valid_o | output | 1 | One-cycle pulse per found entry |
| match_addr_o | output | 32 | Address of the found entry |
| match_idx_o | output | CNT_W | Index of the found entry |
| found_o | output | CNT_W | Number of entries found so far |
| done_o | output | 1 | Target count reached |
| err_o | output | 1 | Search window overrun |

## Verification
Because the hash stage sits in front of the compare, a new candidate can be accepted in the very cycle a completing match is judged. The bench provokes this by holding valid across two congruent candidates when the target is 2. It then expects exactly one pulse and a found count that stays at the target. A restart can also coincide with a candidate at the compare stage; the bench asserts `start_i` one cycle after a congruent handshake and expects no pulse for that candidate, followed by the new reference as entry 0. All slice hashes are predicted from bit-position lists across both modes and every selector value.

// File: rtl/scf_pkg.sv
package scf_pkg;
    localparam int ADDR_W   = 32;
    localparam int TSEL_MIN = 17;

    // parity masks over the upper address bits
    localparam logic [ADDR_W-1:0] MASK_PAIR = 32'h5F56_0000;
    localparam logic [ADDR_W-1:0] MASK_LO   = 32'hEAAC_0000;
    localparam logic [ADDR_W-1:0] MASK_HI   = 32'hB5FA_0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_SCAN,
        ST_DONE,
        ST_FAIL
    } scf_state_e;
endpackage

// File: rtl/scf_hash.sv
module scf_hash
    import scf_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              mode4_i,
    input  logic              test_en_i,
    input  logic [4:0]        test_sel_i,
    output logic [1:0]        hash_o
);
    logic par_pair, par_lo, par_hi, fold;

    always_comb begin
        par_pair = ^(addr_i & MASK_PAIR);
        par_lo   = ^(addr_i & MASK_LO);
        par_hi   = ^(addr_i & MASK_HI);
        fold     = 1'b0;
        if (test_en_i && (int'(test_sel_i) >= TSEL_MIN))
            fold = addr_i[test_sel_i];
        hash_o = mode4_i ? {par_hi, par_lo ^ fold} : {1'b0, par_pair ^ fold};
    end
endmodule

// File: rtl/scf_cand_stage.sv
module scf_cand_stage #(
    parameter int AW = 32,
    parameter int HW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [AW-1:0] addr_i,
    input  logic [HW-1:0] hash_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o,
    output logic [HW-1:0] hash_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            addr_o  <= '0;
            hash_o  <= '0;
        end else begin
            valid_o <= take_i;
            if (take_i) begin
                addr_o <= addr_i;
                hash_o <= hash_i;
            end
        end
    end
endmodule

// File: rtl/slice_congr_filter.sv
module slice_congr_filter
    import scf_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int SET_W = 17,
    parameter int BUF_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       ref_addr_i,
    input  logic [CNT_W-1:0]  target_i,
    input  logic              mode4_i,
    input  logic              test_en_i,
    input  logic [4:0]        test_sel_i,
    input  logic              cand_valid_i,
    input  logic [31:0]       cand_addr_i,
    output logic              cand_ready_o,
    output logic              match_valid_o,
    output logic [31:0]       match_addr_o,
    output logic [CNT_W-1:0]  match_idx_o,
    output logic [CNT_W-1:0]  found_o,
    output logic              done_o,
    output logic              err_o
);
    localparam logic [ADDR_W:0]  BUF_SPAN = (ADDR_W+1)'(1) << BUF_W;
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    scf_state_e           state_q, state_d;
    logic [ADDR_W-1:0]    ref_q;
    logic [ADDR_W:0]      end_q;
    logic [CNT_W-1:0]     tgt_q, tgt_eff, cnt_q, cnt_inc;
    logic                 mode_q, ten_q;
    logic [4:0]           tsel_q;
    logic [1:0]           ref_hash_w, ref_hash_q, cand_hash_w, s1_hash;
    logic                 s1_v, take, cong, overrun;
    logic [ADDR_W-1:0]    s1_addr;

    scf_hash u_ref_hash (
        .addr_i(ref_q), .mode4_i(mode_q), .test_en_i(ten_q),
        .test_sel_i(tsel_q), .hash_o(ref_hash_w)
    );

    scf_hash u_cand_hash (
        .addr_i(cand_addr_i), .mode4_i(mode_q), .test_en_i(ten_q),
        .test_sel_i(tsel_q), .hash_o(cand_hash_w)
    );

    assign cand_ready_o = (state_q == ST_SCAN);
    assign take         = cand_valid_i && cand_ready_o && !start_i;

    scf_cand_stage #(.AW(ADDR_W), .HW(2)) u_stage (
        .clk(clk), .rst_n(rst_n), .take_i(take), .addr_i(cand_addr_i),
        .hash_i(cand_hash_w), .valid_o(s1_v), .addr_o(s1_addr), .hash_o(s1_hash)
    );

    assign tgt_eff = (tgt_q == '0) ? ONE : tgt_q;
    assign cnt_inc = cnt_q + ONE;
    assign overrun = ({1'b0, s1_addr} >= end_q);
    assign cong    = (s1_addr[SET_W-1:0] == ref_q[SET_W-1:0]) && (s1_hash == ref_hash_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_IDLE;
            ST_PREP: state_d = (tgt_eff == ONE) ? ST_DONE : ST_SCAN;
            ST_SCAN: begin
                if (s1_v) begin
                    if (overrun)                        state_d = ST_FAIL;
                    else if (cong && cnt_inc == tgt_eff) state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_DONE;
            ST_FAIL: state_d = ST_FAIL;
        endcase
        if (start_i) state_d = ST_PREP;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q         <= '0;
            end_q         <= '0;
            tgt_q         <= '0;
            mode_q        <= 1'b0;
            ten_q         <= 1'b0;
            tsel_q        <= '0;
            ref_hash_q    <= '0;
            cnt_q         <= '0;
            match_valid_o <= 1'b0;
            match_addr_o  <= '0;
            match_idx_o   <= '0;
        end else begin
            match_valid_o <= 1'b0;
            if (start_i) begin
                ref_q  <= ref_addr_i;
                tgt_q  <= target_i;
                mode_q <= mode4_i;
                ten_q  <= test_en_i;
                tsel_q <= test_sel_i;
                cnt_q  <= '0;
            end else begin
                unique case (state_q)
                    ST_PREP: begin
                        ref_hash_q    <= ref_hash_w;
                        end_q         <= {1'b0, ref_q} + BUF_SPAN;
                        match_valid_o <= 1'b1;
                        match_addr_o  <= ref_q;
                        match_idx_o   <= '0;
                        cnt_q         <= ONE;
                    end
                    ST_SCAN: begin
                        if (s1_v && !overrun && cong) begin
                            match_valid_o <= 1'b1;
                            match_addr_o  <= s1_addr;
                            match_idx_o   <= cnt_q;
                            cnt_q         <= cnt_inc;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign found_o = cnt_q;
    assign done_o  = (state_q == ST_DONE);
    assign err_o   = (state_q == ST_FAIL);

    // R7: emitted index trails the count by one
    a_r7_idx_follows_count: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid_o |-> (match_idx_o + ONE) == found_o);

    // R3: every emitted entry shares the in-slice set bits of the reference
    a_r3_match_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid_o |-> match_addr_o[SET_W-1:0] == ref_q[SET_W-1:0]);

    // R10: a restart clears count, error and pending pulse
    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (found_o == '0) && !err_o && !match_valid_o);

    // R8: the count never passes the target
    a_r8_found_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        found_o <= tgt_eff);

    // R12: no acceptance once finished or failed
    a_r12_ready_scan: assert property (@(posedge clk) disable iff (!rst_n)
        cand_ready_o |-> !done_o && !err_o);

    // R9: a failed search emits nothing
    a_r9_no_match_in_fail: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !match_valid_o);
endmodule

// File: tb/slice_congr_filter_tb.sv
module slice_congr_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;
    localparam int WD_CYCLES  = 100000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 0, mode4_i = 0, test_en_i = 0, cand_valid_i = 0;
    logic [31:0] ref_addr_i = '0, cand_addr_i = '0;
    logic [CNT_W-1:0] target_i = '0;
    logic [4:0] test_sel_i = '0;
    logic cand_ready_o, match_valid_o, done_o, err_o;
    logic [31:0] match_addr_o;
    logic [CNT_W-1:0] match_idx_o, found_o;

    int n_checks = 0, n_fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slice_congr_filter #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_addr_i(ref_addr_i),
        .target_i(target_i), .mode4_i(mode4_i), .test_en_i(test_en_i),
        .test_sel_i(test_sel_i), .cand_valid_i(cand_valid_i), .cand_addr_i(cand_addr_i),
        .cand_ready_o(cand_ready_o), .match_valid_o(match_valid_o),
        .match_addr_o(match_addr_o), .match_idx_o(match_idx_o), .found_o(found_o),
        .done_o(done_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] mhash(logic [31:0] a, bit m4, bit te, int ts);
        int pb[10] = '{17, 18, 20, 22, 24, 25, 26, 27, 28, 30};
        int lb[9]  = '{18, 19, 21, 23, 25, 27, 29, 30, 31};
        int hb[11] = '{17, 19, 20, 21, 22, 23, 24, 26, 28, 29, 31};
        logic p = 0, l = 0, h = 0, f = 0;
        foreach (pb[i]) p ^= a[pb[i]];
        foreach (lb[i]) l ^= a[lb[i]];
        foreach (hb[i]) h ^= a[hb[i]];
        if (te && ts >= 17 && ts <= 31) f = a[ts];
        return m4 ? {h, l ^ f} : {1'b0, p ^ f};
    endfunction

    function automatic bit mcong(logic [31:0] a, logic [31:0] r, bit m4, bit te, int ts);
        return (a[16:0] == r[16:0]) && (mhash(a, m4, te, ts) == mhash(r, m4, te, ts));
    endfunction

    function automatic logic [31:0] next_cong(logic [31:0] r, bit m4, bit te, int ts, int k0);
        for (int k = k0; k < 128; k++)
            if (mcong(r + 32'(k) * 32'h2_0000, r, m4, te, ts)) return r + 32'(k) * 32'h2_0000;
        return r;
    endfunction

    task automatic do_start(input logic [31:0] r, input bit m4, input bit te, input int ts,
                            input int tgt);
        @(negedge clk);
        start_i = 1; ref_addr_i = r; mode4_i = m4; test_en_i = te;
        test_sel_i = 5'(ts); target_i = CNT_W'(tgt);
        @(negedge clk);
        start_i = 0;
        check(found_o == 0 && !cand_ready_o, "R2", "count cleared after start", found_o, 0);
        @(negedge clk);
        check(match_valid_o && match_addr_o == r && match_idx_o == 0 && found_o == 1,
              "R2", "reference emitted as entry 0", match_addr_o, r);
    endtask

    task automatic send_one(input logic [31:0] a, input bit exp_m, input int exp_idx,
                            input string req);
        @(negedge clk);
        cand_valid_i = 1; cand_addr_i = a;
        @(negedge clk);
        cand_valid_i = 0;
        @(negedge clk);
        check(match_valid_o == exp_m &&
              (!exp_m || (match_addr_o == a && match_idx_o == CNT_W'(exp_idx))),
              req, "candidate result", {match_valid_o, match_addr_o}, {exp_m, a});
        check(found_o == CNT_W'(exp_idx + (exp_m ? 1 : 0)), req, "found count",
              found_o, exp_idx + (exp_m ? 1 : 0));
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] r, a, b;
        int found;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(!cand_ready_o && !match_valid_o && !done_o && !err_o && found_o == 0,
              "R1", "reset outputs", {cand_ready_o, match_valid_o, done_o, err_o}, 0);

        // R3 R4 R5 R6 R7 R12: sweep modes and every selector value
        for (int m = 0; m < 2; m++) begin
            for (int si = 0; si < 17; si++) begin
                bit te = (si != 0);
                int ts = (si == 0) ? 20 : ((si == 1) ? 5 : 15 + si);
                r = {8'(si * 8 + m), 24'hF4_0ABC};
                do_start(r, bit'(m), te, ts, 63);
                check(cand_ready_o, "R12", "ready in scan", cand_ready_o, 1);
                found = 1;
                for (int k = 1; k <= 40; k++) begin
                    bit e;
                    a = r + 32'(k) * 32'h2_0000;
                    e = mcong(a, r, bit'(m), te, ts);
                    send_one(a, e, found, m ? "R4/R5" : "R3/R5");
                    if (e) found++;
                end
            end
        end

        // R6: page-stepped candidates with differing low bits never match
        r = 32'h1234_5000;
        do_start(r, 0, 0, 0, 63);
        for (int k = 1; k <= 31; k++)
            send_one(r + 32'(k) * 32'h1000, 0, 1, "R6");

        // R8: target 0 finishes on reference alone
        do_start(32'h0040_0000, 1, 0, 0, 0);
        check(done_o && !cand_ready_o && found_o == 1, "R8", "target 0 done", found_o, 1);

        // R8: target 3 then candidates ignored
        r = 32'h0A00_0040;
        do_start(r, 1, 0, 0, 3);
        a = next_cong(r, 1, 0, 0, 1);
        b = next_cong(r, 1, 0, 0, int'((a - r) >> 17) + 1);
        send_one(a, 1, 1, "R8");
        check(!done_o, "R8", "not done early", done_o, 0);
        send_one(b, 1, 2, "R8");
        check(done_o && !cand_ready_o, "R8", "done at target", done_o, 1);
        send_one(b, 0, 3, "R8");

        // R11: back-to-back candidates at completion
        r = 32'h0B00_0100;
        do_start(r, 0, 0, 0, 2);
        a = next_cong(r, 0, 0, 0, 1);
        b = next_cong(r, 0, 0, 0, int'((a - r) >> 17) + 1);
        @(negedge clk); cand_valid_i = 1; cand_addr_i = a;
        @(negedge clk); cand_addr_i = b;
        @(negedge clk); cand_valid_i = 0;
        check(match_valid_o && match_addr_o == a && found_o == 2 && done_o,
              "R11", "completing match", match_addr_o, a);
        @(negedge clk);
        check(!match_valid_o && found_o == 2, "R11", "second candidate dropped",
              {match_valid_o, found_o}, 2);

        // R9: overrun past the 16 MiB window
        r = 32'h2000_0000;
        do_start(r, 0, 0, 0, 63);
        send_one(r + 32'h00FF_F000, 0, 1, "R9");
        check(!err_o, "R9", "last page in window is legal", err_o, 0);
        send_one(r + 32'h0100_0000, 0, 1, "R9");
        check(err_o && !cand_ready_o && !done_o, "R9", "overrun error", err_o, 1);

        // R10: restart clears error; start coincides with a candidate at compare
        r = 32'h3000_0200;
        do_start(r, 1, 0, 0, 63);
        check(!err_o, "R10", "error cleared by start", err_o, 0);
        a = next_cong(r, 1, 0, 0, 1);
        b = 32'h4400_0300;
        @(negedge clk); cand_valid_i = 1; cand_addr_i = a;
        @(negedge clk); cand_valid_i = 0; start_i = 1; ref_addr_i = b; target_i = 5;
        @(negedge clk); start_i = 0;
        check(!match_valid_o && found_o == 0 && !err_o, "R10", "in-flight match squashed",
              {match_valid_o, found_o}, 0);
        @(negedge clk);
        check(match_valid_o && match_addr_o == b && match_idx_o == 0 && found_o == 1,
              "R10", "new reference entry", match_addr_o, b);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule